// File: doc/BRIEF.md
# I2S Channel Select and Mono Mixer

This block takes a serial stereo audio stream in standard I2S framing and turns it into one signed mono sample per frame. The bit clock, the serial data line and two word-select pins come in, and all of them are sampled on the system clock. No register picks the channel. The choice comes from which word-select pin is actually toggling. Wiring the frame clock to the left pin selects the left word. Wiring it to the right pin selects the right word. Wiring it to both pins gives the average of the two words.

A pin counts as toggling once it has changed level twice, with the second change coming less than one frame period (counted in bit clocks) after the first. A pin that stays still for a full frame period stops counting as active. When neither pin is active, the block raises its mute flag, forces the sample to zero and stops issuing valid strobes. The result is presented once per frame, after the right-hand slot ends. It sits in output registers and is marked by a single-cycle strobe.

Top module: `i2s_mono_select`

## Requirements
- R1: While reset is high and on the cycle after it, `sample_o` is 0, `valid_o` is 0 and `mute_o` is 1.
- R2: Each slot carries a word sent MSB first, with the MSB on the second rising bit-clock edge after the word-select change. Frame-clock low marks the left slot and frame-clock high marks the right slot. A 16-bit word such as 0xC3A5 comes out unreversed.
- R3: With only `wsl_i` toggling (and `wsr_i` held still), `sample_o` equals the left word of the frame. `valid_o` pulses for one cycle, exactly once per frame.
- R4: With only `wsr_i` toggling, `sample_o` equals the right word of the frame, once per frame.
- R5: With both pins toggling, `sample_o` is (L+R) computed on 17 bits and then shifted right arithmetically by one, which rounds toward minus infinity. For example, 100 and -301 give -101.
- R6: The mix never wraps at full scale: 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000, and 0x7FFF+0x8000 gives 0xFFFF.
- R7: If neither pin changes for a frame period (2×16 = 32 bit clocks by default), then `mute_o` becomes 1, `sample_o` becomes 0 and no `valid_o` pulse is issued.
- R8: A single level change on a word-select pin does not end mute. A second change less than one frame period after the first makes the pin active again.
- R9: When a slot is longer than 16 bit clocks, the bits after the 16th are ignored. With 24-bit slots, the output uses only the first 16 bits of each slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| sd_i | input | 1 | Serial audio data, MSB first |
| wsl_i | input | 1 | Word-select pin that, when toggling, selects the left word |
| wsr_i | input | 1 | Word-select pin that, when toggling, selects the right word |
| sample_o | output | 16 | Signed mono sample, held between strobes |
| valid_o | output | 1 | One-cycle strobe marking a new `sample_o` |
| mute_o | output | 1 | High while no word-select pin is active; sample then zero |

## Verification
Three values test the mix: 100 with -301, and the paired full-scale extremes. A design that shifts logically or drops the headroom bit would output a large positive number or a wrapped sign. A left-only pattern with an asymmetric word catches a receiver that puts the bits in LSB-first or starts one bit early. It also catches one that takes the data bit from the word-select edge as the MSB. Long 24-bit slots with trailing ones expose a receiver that keeps the last 16 bits instead of the first 16. A run where a pin changes once and then holds exposes an activity detector that unmutes on the first change. A pin that goes quiet while the bit clock keeps running checks that mute arrives, that the sample falls to zero and that no strobes come out.

// File: rtl/i2s_mono_pkg.sv
package i2s_mono_pkg;

  // Output source, decoded from which word-select pins are active.
  typedef enum logic [1:0] {
    MODE_MUTE  = 2'd0,
    MODE_LEFT  = 2'd1,
    MODE_RIGHT = 2'd2,
    MODE_MIX   = 2'd3
  } mix_mode_e;

endpackage

// File: rtl/ws_activity.sv
module ws_activity #(
  parameter int GAP_BCK = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ws_in,
  output logic active
);
  localparam int GW = $clog2(GAP_BCK + 2);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_BCK);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_BCK + 1);

  logic          ws_last;
  logic          seen_one;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_last  <= 1'b0;
      seen_one <= 1'b0;
      gap      <= '0;
      active   <= 1'b0;
    end else if (tick) begin
      ws_last <= ws_in;
      if (ws_in != ws_last) begin
        gap      <= '0;
        seen_one <= 1'b1;
        if (seen_one && gap < GAP_V) active <= 1'b1;
      end else begin
        if (gap != GAP_SAT) gap <= gap + 1'b1;
        if (gap >= GAP_V) begin
          active   <= 1'b0;
          seen_one <= 1'b0;
        end
      end
    end
  end

  // R8: an active pin has changed level within the last frame period
  assert_active_recent_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (gap <= GAP_V));

endmodule

// File: rtl/i2s_slot_rx.sv
module i2s_slot_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ws,
  input  logic         sd,
  output logic         done,
  output logic         done_right,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] W_V = CW'(W);

  logic          ws_last;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  sh_nxt;

  // Place the current bit at its MSB-first position; bits past W are dropped.
  always_comb begin
    sh_nxt = sh;
    for (int i = 0; i < W; i++) begin
      if (cnt < W_V && i == W - 1 - int'(cnt)) sh_nxt[i] = sd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_last    <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      done       <= 1'b0;
      done_right <= 1'b0;
      word       <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        ws_last <= ws;
        if (ws != ws_last) begin
          // The bit on the select edge is still the previous slot's last bit.
          word       <= sh_nxt;
          done       <= 1'b1;
          done_right <= ws_last;
          sh         <= '0;
          cnt        <= '0;
        end else begin
          sh <= sh_nxt;
          if (cnt < W_V) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: the bit position never runs past the word
  assert_bitcnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= W_V);

endmodule

// File: rtl/mono_out_stage.sv
module mono_out_stage
  import i2s_mono_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  mix_mode_e           mode,
  input  logic                done,
  input  logic                done_right,
  input  logic [W-1:0]        word,
  output logic signed [W-1:0] sample_o,
  output logic                valid_o,
  output logic                mute_o
);
  logic signed [W-1:0] left_q;
  logic signed [W-1:0] right_s;
  logic signed [W:0]   sum;
  logic signed [W-1:0] avg;
  logic signed [W-1:0] pick;

  assign right_s = $signed(word);
  assign sum     = {left_q[W-1], left_q} + {right_s[W-1], right_s};
  assign avg     = W'(sum >>> 1);

  always_comb begin
    case (mode)
      MODE_LEFT:  pick = left_q;
      MODE_RIGHT: pick = right_s;
      MODE_MIX:   pick = avg;
      default:    pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
      mute_o   <= 1'b1;
    end else begin
      valid_o <= 1'b0;
      mute_o  <= (mode == MODE_MUTE);
      if (done && !done_right) left_q <= right_s;
      if (mode == MODE_MUTE) begin
        sample_o <= '0;
      end else if (done && done_right) begin
        sample_o <= pick;
        valid_o  <= 1'b1;
      end
    end
  end

  // R5: the average lies between the two inputs, so it cannot wrap
  assert_mix_between_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MIX) |->
      ((avg >= left_q && avg <= right_s) || (avg >= right_s && avg <= left_q)));

endmodule

// File: rtl/i2s_mono_select.sv
module i2s_mono_select
  import i2s_mono_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAP_BCK  = 2 * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bck_i,
  input  logic                       sd_i,
  input  logic                       wsl_i,
  input  logic                       wsr_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o,
  output logic                       mute_o
);
  logic bck_q, bck_qq, sd_q, wsl_q, wsr_q;
  logic tick;
  logic [1:0] ws_pin;
  logic [1:0] act;
  logic ws_eff;
  mix_mode_e mode;
  logic done, done_right;
  logic [SAMPLE_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_q  <= 1'b0;
      bck_qq <= 1'b0;
      sd_q   <= 1'b0;
      wsl_q  <= 1'b0;
      wsr_q  <= 1'b0;
    end else begin
      bck_q  <= bck_i;
      bck_qq <= bck_q;
      sd_q   <= sd_i;
      wsl_q  <= wsl_i;
      wsr_q  <= wsr_i;
    end
  end

  assign tick   = bck_q & ~bck_qq;
  assign ws_pin = {wsr_q, wsl_q};

  for (genvar g = 0; g < 2; g++) begin : g_act
    ws_activity #(.GAP_BCK(GAP_BCK)) u_act (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .ws_in  (ws_pin[g]),
      .active (act[g])
    );
  end

  always_comb begin
    case (act)
      2'b01:   mode = MODE_LEFT;
      2'b10:   mode = MODE_RIGHT;
      2'b11:   mode = MODE_MIX;
      default: mode = MODE_MUTE;
    endcase
  end

  // Frame timing follows the left pin when it is active, else the right pin.
  assign ws_eff = act[0] ? wsl_q : wsr_q;

  i2s_slot_rx #(.W(SAMPLE_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ws         (ws_eff),
    .sd         (sd_q),
    .done       (done),
    .done_right (done_right),
    .word       (word)
  );

  mono_out_stage #(.W(SAMPLE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .done       (done),
    .done_right (done_right),
    .word       (word),
    .sample_o   (sample_o),
    .valid_o    (valid_o),
    .mute_o     (mute_o)
  );

  // R7: no active pin forces mute on the next cycle
  assert_mute_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (act == 2'b00) |=> mute_o);

  // R7: a muted output carries zero
  assert_mute_zero_R7: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> (sample_o == '0));

  // R3: the strobe lasts a single cycle
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

endmodule

// File: tb/i2s_mono_select_bench.sv
module i2s_mono_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BCK_HALF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bck = 1'b0, sd = 1'b0, wsl = 1'b0, wsr = 1'b0;
  logic signed [15:0] sample_o;
  logic valid_o, mute_o;

  int tests = 0;
  int fails = 0;
  int vcnt  = 0;
  logic signed [15:0] last_s = '0;

  i2s_mono_select u_i2s_mono_select (
    .clk(clk), .rst(rst), .bck_i(bck), .sd_i(sd), .wsl_i(wsl), .wsr_i(wsr),
    .sample_o(sample_o), .valid_o(valid_o), .mute_o(mute_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      vcnt   <= vcnt + 1;
      last_s <= sample_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input logic w, input bit ul, input bit ur);
    bck = 1'b0;
    sd  = d;
    wsl = ul ? w : 1'b0;
    wsr = ur ? w : 1'b0;
    repeat (BCK_HALF) @(negedge clk);
    bck = 1'b1;
    repeat (BCK_HALF) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int slot,
                            input bit ul, input bit ur, input logic fill);
    for (int j = 0; j < slot; j++)
      send_bit((j < 16) ? l[15 - j] : fill, (j == slot - 1), ul, ur);
    for (int j = 0; j < slot; j++)
      send_bit((j < 16) ? r[15 - j] : fill, (j != slot - 1), ul, ur);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_bits(input int n, input logic wl, input logic wr);
    for (int j = 0; j < n; j++) begin
      bck = 1'b0; sd = j[0]; wsl = wl; wsr = wr;
      repeat (BCK_HALF) @(negedge clk);
      bck = 1'b1;
      repeat (BCK_HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic int mix_ref(input logic [15:0] l, input logic [15:0] r);
    int s;
    s = int'($signed(l)) + int'($signed(r));
    return s >>> 1;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(mute_o === 1'b1, "R1 mute in reset", int'(mute_o), 1);
    check(valid_o === 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(sample_o === 16'sd0, "R1 sample in reset", int'(sample_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(mute_o === 1'b1, "R1 mute after reset", int'(mute_o), 1);
  endtask

  task automatic t_left_only;
    int v0;
    send_frame(16'h1111, 16'h2222, 16, 1, 0, 1'b0);
    send_frame(16'h1111, 16'h2222, 16, 1, 0, 1'b0);
    v0 = vcnt;
    send_frame(16'h0F0F, 16'h7777, 16, 1, 0, 1'b0);
    send_frame(16'hC3A5, 16'hABCD, 16, 1, 0, 1'b0);
    check(last_s === 16'hC3A5, "R2 R3 left word MSB first", int'(last_s), int'($signed(16'hC3A5)));
    check(vcnt - v0 == 2, "R3 one strobe per frame", vcnt - v0, 2);
    check(mute_o === 1'b0, "R3 not muted", int'(mute_o), 0);
  endtask

  task automatic t_right_only;
    repeat (3) send_frame(16'h5555, 16'h3333, 16, 0, 1, 1'b0);
    send_frame(16'h1234, 16'h8421, 16, 0, 1, 1'b0);
    check(last_s === 16'h8421, "R4 right word", int'(last_s), int'($signed(16'h8421)));
    check(mute_o === 1'b0, "R4 not muted", int'(mute_o), 0);
  endtask

  task automatic t_mix;
    repeat (3) send_frame(16'd10, 16'd20, 16, 1, 1, 1'b0);
    send_frame(16'd100, 16'hFED3, 16, 1, 1, 1'b0);
    check(int'(last_s) == -101, "R5 mix 100 and -301", int'(last_s), -101);
    check(int'(last_s) == mix_ref(16'd100, 16'hFED3), "R5 mix reference", int'(last_s),
          mix_ref(16'd100, 16'hFED3));
    send_frame(16'd3, 16'd4, 16, 1, 1, 1'b0);
    check(int'(last_s) == 3, "R5 mix 3 and 4", int'(last_s), 3);
  endtask

  task automatic t_mix_extreme;
    send_frame(16'h7FFF, 16'h7FFF, 16, 1, 1, 1'b0);
    check(last_s === 16'h7FFF, "R6 positive full scale", int'(last_s), 32767);
    send_frame(16'h8000, 16'h8000, 16, 1, 1, 1'b0);
    check(last_s === 16'h8000, "R6 negative full scale", int'(last_s), -32768);
    send_frame(16'h7FFF, 16'h8000, 16, 1, 1, 1'b0);
    check(last_s === 16'hFFFF, "R6 opposite full scale", int'(last_s), -1);
  endtask

  task automatic t_long_slot;
    send_frame(16'h1111, 16'h1111, 24, 1, 1, 1'b1);
    send_frame(16'h1357, 16'h2468, 24, 1, 1, 1'b1);
    check(int'(last_s) == mix_ref(16'h1357, 16'h2468), "R9 first 16 bits of long slot",
          int'(last_s), mix_ref(16'h1357, 16'h2468));
  endtask

  task automatic t_mute;
    int v0;
    v0 = vcnt;
    idle_bits(40, 1'b0, 1'b0);
    check(mute_o === 1'b1, "R7 mute after quiet frame", int'(mute_o), 1);
    check(sample_o === 16'sd0, "R7 zero sample when muted", int'(sample_o), 0);
    check(vcnt == v0, "R7 no strobe when muted", vcnt - v0, 0);
  endtask

  task automatic t_single_toggle;
    int v0;
    v0 = vcnt;
    idle_bits(8, 1'b1, 1'b0);
    check(mute_o === 1'b1, "R8 single change keeps mute", int'(mute_o), 1);
    idle_bits(40, 1'b1, 1'b0);
    check(mute_o === 1'b1, "R8 still muted after hold", int'(mute_o), 1);
    check(vcnt == v0, "R8 no strobe on single change", vcnt - v0, 0);
    send_frame(16'h0101, 16'h0202, 16, 1, 0, 1'b0);
    send_frame(16'h4321, 16'h0202, 16, 1, 0, 1'b0);
    check(mute_o === 1'b0, "R8 two changes end mute", int'(mute_o), 0);
    check(last_s === 16'h4321, "R8 left word after unmute", int'(last_s), int'(16'h4321));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_left_only();
    t_right_only();
    t_mix();
    t_mix_extreme();
    t_long_slot();
    t_mute();
    t_single_toggle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule